// File: doc/BRIEF.md
# Divider Configuration Load Port

This block holds the setting of a clock synthesizer: a 9-bit feedback modulus (M), a 2-bit output modulus (N) and a 3-bit test code (T). The setting arrives in one of two ways. The first is a parallel bus with its own load strobe. The second is a three-wire serial port made of a data line, a shift clock and a load strobe. The serial side feeds a 14-bit shift register, and its load strobe copies the whole register into the setting.

All external pins are asynchronous to the fast system clock. They pass through a multi-stage synchronizer, and every edge and level is then acted on in the system clock domain.

The two loaders see through to the setting at opposite strobe levels:

- The parallel strobe makes the M and N fields follow the bus while it is low.
- The serial strobe makes all three fields follow the shift register while it is high.

The parallel side always wins. The test code can only be written through the serial port, and it is held at zero whenever the parallel strobe is low. The oldest bit in the shift register is brought out on a pin of its own.

Top module: `cfg_load_if`

## Requirements
- R1: A synchronous reset clears all 14 shift register bits, M, N and T to zero, so every output reads zero after reset.
- R2: The shift register moves by exactly one position for each low-to-high transition of `ser_clk`, taking in `ser_data` at its low end. A high-to-low transition or a steady level leaves it unchanged.
- R3: After 14 shifts, the first bit sent sits at register bit 13 and the last at bit 0. The field split is: bits 13..11 form T (bit 13 is T's MSB), bits 10..9 form N, and bits 8..0 form M (bit 8 is M's MSB).
- R4: While `par_load` is high and `ser_load` is high, M, N and T follow the shift register. Once `ser_load` falls, they hold the value they had at that transition, and later shifting does not change them.
- R5: While `par_load` is low, M follows `par_m` and N follows `par_n`. After `par_load` rises, both hold the values they had at the rising transition.
- R6: While `par_load` is low, `ser_load` has no effect on M, N or T.
- R7: T cannot be written from the parallel pins. T reads 000 whenever `par_load` is low, and it stays 000 after `par_load` rises until the next serial load.
- R8: `shift_out` always shows register bit 13, which is the bit shifted in 14 transitions earlier.
- R9: A change on a pin reaches the outputs exactly SYNC_STAGES+1 system clock edges later. Earlier edges still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load | input | 1 | Parallel strobe: see-through while low, capture on rising edge |
| par_m | input | 9 | Parallel feedback modulus |
| par_n | input | 2 | Parallel output modulus |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, active on its rising edge |
| ser_load | input | 1 | Serial strobe: see-through while high, hold on falling edge |
| m_val | output | 9 | Current feedback modulus |
| n_val | output | 2 | Current output modulus |
| t_val | output | 3 | Current test code |
| shift_out | output | 1 | Oldest bit of the shift register |

## Verification
The bench builds the block with its default widths: a 9-bit M, a 2-bit N, a 3-bit T and two synchronizer stages. With two stages the see-through latency is three edges, so the bench can count the exact edge at which a pin change appears and also confirm that the edge before it still shows the old value. The 14-bit frame is short enough to send complete frames, then extra bits, then a second frame with different field values. This exercises the bit order, the field boundaries and the shift-out pin in the same run.

// File: rtl/cfgif_pkg.sv
package cfgif_pkg;
  localparam int M_WIDTH_D = 9;
  localparam int N_WIDTH_D = 2;
  localparam int T_WIDTH_D = 3;
  localparam int SYNC_D    = 2;
endpackage

// File: rtl/cfgif_sync.sv
module cfgif_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgif_shift.sv
module cfgif_shift #(
  parameter int LEN = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk_s,
  input  logic           sdat_s,
  output logic [LEN-1:0] sreg
);
  logic sclk_d;
  logic rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sreg   <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) sreg <= {sreg[LEN-2:0], sdat_s};
    end
  end

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!sclk_s || sclk_d) |=> $stable(sreg)); // R2
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (sclk_s && !sclk_d) |=> (sreg[LEN-1:1] == $past(sreg[LEN-2:0]))); // R2
endmodule

// File: rtl/cfgif_latch.sv
module cfgif_latch #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int LEN = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pl_s,
  input  logic           sl_s,
  input  logic [LEN-1:0] sreg,
  input  logic [M_W-1:0] pm_s,
  input  logic [N_W-1:0] pn_s,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (!pl_s) begin
      m_q <= pm_s;
      n_q <= pn_s;
      t_q <= '0;
    end else if (sl_s) begin
      t_q <= sreg[LEN-1 -: T_W];
      n_q <= sreg[M_W +: N_W];
      m_q <= sreg[M_W-1:0];
    end
  end

  AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (t_q == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sl_s) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q))); // R4
endmodule

// File: rtl/cfg_load_if.sv
module cfg_load_if
  import cfgif_pkg::*;
#(
  parameter int M_W = M_WIDTH_D,
  parameter int N_W = N_WIDTH_D,
  parameter int T_W = T_WIDTH_D,
  parameter int SYNC_STAGES = SYNC_D
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           shift_out
);
  localparam int LEN   = M_W + N_W + T_W;
  localparam int BUS_W = M_W + N_W + 4;
  localparam logic [BUS_W-1:0] SYNC_RST = {1'b1, {(BUS_W-1){1'b0}}};

  logic [BUS_W-1:0] raw_bus, syn_bus;
  logic             pl_s, sl_s, sclk_s, sdat_s;
  logic [M_W-1:0]   pm_s;
  logic [N_W-1:0]   pn_s;
  logic [LEN-1:0]   sreg;

  assign raw_bus = {par_load, ser_load, ser_clk, ser_data, par_n, par_m};

  cfgif_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign {pl_s, sl_s, sclk_s, sdat_s, pn_s, pm_s} = syn_bus;

  cfgif_shift #(.LEN(LEN)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdat_s(sdat_s), .sreg(sreg)
  );

  cfgif_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
    .clk(clk), .rst(rst), .pl_s(pl_s), .sl_s(sl_s), .sreg(sreg),
    .pm_s(pm_s), .pn_s(pn_s), .m_q(m_val), .n_q(n_val), .t_q(t_val)
  );

  assign shift_out = sreg[LEN-1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (m_val == '0 && n_val == '0 && t_val == '0 && sreg == '0)); // R1
  AST_PAR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (!pl_s && sl_s) |=> (t_val == '0)); // R6
endmodule

// File: tb/tb_cfg_load_if.sv
module tb_cfg_load_if;
  localparam int MW = 9;
  localparam int NW = 2;
  localparam int TW = 3;

  typedef struct {
    logic [MW-1:0] m;
    logic [NW-1:0] n;
    logic [TW-1:0] t;
    logic          sh;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_load = 1'b1;
  logic [MW-1:0] par_m = '1;
  logic [NW-1:0] par_n = '1;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
  logic [MW-1:0] m_val;
  logic [NW-1:0] n_val;
  logic [TW-1:0] t_val;
  logic shift_out;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];
  logic [13:0] model_sr = '0;

  always #10 clk = ~clk;

  cfg_load_if dut (
    .clk(clk), .rst(rst), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .shift_out(shift_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [MW-1:0] m, input logic [NW-1:0] n,
                      input logic [TW-1:0] t, input string tag);
    exp_t e;
    e.m = m; e.n = n; e.t = t; e.sh = model_sr[13]; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic wait_neg(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    wait_neg(4); ser_clk = 1'b1;
    wait_neg(4); ser_clk = 1'b0;
    wait_neg(4);
    model_sr = {model_sr[12:0], b};
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_serial_load();
    @(negedge clk) ser_load = 1'b1;
    wait_neg(5); ser_load = 1'b0;
    wait_neg(5);
  endtask

  // monitor: pops expected items once the outputs have settled
  initial begin
    forever begin
      wait (q.size() != 0);
      wait_neg(6);
      check({q[0].tag, " m"}, 32'(m_val), 32'(q[0].m));
      check({q[0].tag, " n"}, 32'(n_val), 32'(q[0].n));
      check({q[0].tag, " t"}, 32'(t_val), 32'(q[0].t));
      check({q[0].tag, " shift_out"}, 32'(shift_out), 32'(q[0].sh));
      void'(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    push('0, '0, '0, "R1 reset");

    // parallel see-through and capture
    @(negedge clk) begin par_load = 1'b0; par_m = 9'h0C8; par_n = 2'b01; end
    push(9'h0C8, 2'b01, 3'b000, "R5 par follow");
    @(negedge clk) par_load = 1'b1;
    wait_neg(6);
    @(negedge clk) begin par_m = 9'h055; par_n = 2'b11; end
    push(9'h0C8, 2'b01, 3'b000, "R5 par hold");

    // latency through synchronizer: three edges
    @(negedge clk) par_load = 1'b0;
    push(9'h055, 2'b11, 3'b000, "R5 par reload");
    @(negedge clk) par_m = 9'h1A3;
    @(posedge clk); @(posedge clk);
    @(negedge clk) check("R9 old value", 32'(m_val), 32'h055);
    @(posedge clk);
    @(negedge clk) check("R9 new value", 32'(m_val), 32'h1A3);
    @(negedge clk) par_load = 1'b1;
    wait_neg(6);

    // serial frame T=110 N=10 M=100000110
    send_word(14'b110_10_100000110);
    push(9'h1A3, 2'b11, 3'b000, "R8 frame shifted no load");
    pulse_serial_load();
    push(9'h106, 2'b10, 3'b110, "R3 R4 serial load");

    // extra bits: no load, config holds, shift_out advances
    send_bit(1'b0);
    send_bit(1'b0);
    push(9'h106, 2'b10, 3'b110, "R2 R4 hold after extra shifts");
    @(negedge clk) ser_clk = 1'b1;
    wait_neg(6);
    model_sr = {model_sr[12:0], ser_data};
    @(negedge clk) ser_clk = 1'b0;
    push(9'h106, 2'b10, 3'b110, "R2 single rise then fall");

    // parallel priority over serial load
    @(negedge clk) begin par_load = 1'b0; ser_load = 1'b1; end
    push(9'h1A3, 2'b11, 3'b000, "R6 R7 parallel wins");
    @(negedge clk) begin ser_load = 1'b0; par_load = 1'b1; end
    push(9'h1A3, 2'b11, 3'b000, "R7 T stays zero");

    // second frame T=001 N=00 M=011111111
    send_word(14'b001_00_011111111);
    pulse_serial_load();
    push(9'h0FF, 2'b00, 3'b001, "R3 second frame");
    @(negedge clk) begin par_load = 1'b0; par_m = 9'h001; par_n = 2'b10; end
    push(9'h001, 2'b10, 3'b000, "R7 T cleared by parallel");
    @(negedge clk) par_load = 1'b1;
    wait_neg(6);

    finish_run();
  end
endmodule